// File: doc/BRIEF.md
# Segment Descriptor Loader and Address Translator

This block keeps one hidden 64-bit descriptor cache per segment register. Writing a 16-bit selector for a segment starts a fetch of that segment's 8-byte descriptor. The descriptor comes from the global table or the local table, and bit 2 of the selector picks which one. The fetch runs as two 32-bit reads over a request/valid memory port. The block then unpacks the descriptor's base, limit and rights into the cache for that segment.

Once a segment is loaded, the block turns a segment number and a 32-bit offset into a 32-bit linear address. It uses only the cached base, limit and rights, so translation never touches memory. Offsets beyond the effective limit are flagged. So are segments whose cache holds no usable descriptor.

The whole block acts only while the protection-enable input is high.

Top module: `segDescUnit`

## Requirements
- R1: An accepted selector write reads the descriptor at table base plus index×8, where the index is selector bits 15..3 and the table is chosen by bit 2 (0 = global, 1 = local). The low word is read first at that address and the high word next at that address plus 4.
- R2: From the cycle after an accepted write, `busy` and `memReq` stay high. Each read completes on a cycle where `memValid` is high. `loadDone` pulses the cycle after the second read completes, and `busy` falls at the same time.
- R3: The cached descriptor is unpacked as follows. The base is low-word bits 31..16, high-word bits 7..0 and high-word bits 31..24. The limit is low-word bits 15..0 plus high-word bits 19..16. The rights byte is high-word bits 15..8, with present = bit 15 and privilege = bits 14..13. The flag nibble is high-word bits 23..20, with granularity = bit 23.
- R4: A translate request is answered one cycle later. If the offset is within the limit, `xlatValid` is high and `xlatAddr` equals the cached base plus the offset, modulo 2^32.
- R5: With granularity 0, an offset greater than the 20-bit byte limit raises `xlatFault` and leaves `xlatValid` low. `xlatValid` and `xlatFault` are never high together.
- R6: With granularity 1, the effective limit is the 20-bit limit shifted left by 12 with the low 12 bits set to ones.
- R7: If the fetched descriptor has present = 0, `loadCode` is 2 on `loadDone`, and the segment keeps its previous cache contents.
- R8: A selector with bits 15..2 all zero is a null selector. It completes with `loadCode` 0 the cycle after the write, issues no memory read, and marks the segment unusable. After reset every segment is unusable. Translating through an unusable segment raises `xlatFault`.
- R9: If index×8+7 exceeds the selected table's 16-bit limit, the load completes the next cycle with `loadCode` 1 and issues no read. The segment keeps its previous contents.
- R10: While `protEn` is 0, selector writes start nothing and translate requests produce neither `xlatValid` nor `xlatFault`.
- R11: A selector write presented while `busy` is high is dropped and never starts a load.
- R12: With each translate result, `xlatRpl` gives the loaded selector's bits 1..0 and `xlatDpl` gives the cached descriptor's privilege field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protEn | input | 1 | Protection enable; the block is inactive when low |
| selWrEn | input | 1 | Selector write strobe |
| selWrSeg | input | 3 | Segment register number for the write |
| selWrData | input | 16 | Selector value |
| gdtBase | input | 32 | Global table base address |
| gdtLimit | input | 16 | Global table byte limit |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | 16 | Local table byte limit |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | 32 | Descriptor read address |
| memValid | input | 1 | Read data valid; completes the current read |
| memData | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| loadDone | output | 1 | One-cycle pulse when a load finishes |
| loadCode | output | 2 | Load result: 0 ok or null, 1 table overrun, 2 not present |
| xlatEn | input | 1 | Translate request |
| xlatSeg | input | 3 | Segment number to translate through |
| xlatOffset | input | 32 | Offset within the segment |
| xlatValid | output | 1 | Translated address valid |
| xlatFault | output | 1 | Translation fault (unusable segment or limit) |
| xlatAddr | output | 32 | Linear address |
| xlatRpl | output | 2 | Requested privilege of the segment's selector |
| xlatDpl | output | 2 | Descriptor privilege of the segment |

## Verification
A translate result is due on the clock edge that samples `xlatEn`. The bench raises the request half a period before that edge and reads the outputs at the following falling edge. A null or overrun load reports on the edge right after the write. A fetched load with a zero-wait memory shows the low-word address one cycle after the write, the high-word address one cycle later, and `loadDone` on the third edge. The bench checks `memAddr` at each of those falling edges. One directed case holds `memValid` low for several cycles and confirms that the schedule shifts by exactly the stall length.

// File: rtl/segDescPkg.sv
package segDescPkg;

  typedef enum logic [1:0] {
    LD_OK      = 2'd0,
    LD_OVERRUN = 2'd1,
    LD_ABSENT  = 2'd2
  } ldCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSel;
    logic latchLo;
    logic commitDesc;
    logic commitNull;
    logic useHi;
  } ctrlStrobe_t;

  // hidden cache layout: [63:52] rights, [51:20] base, [19:0] limit
  typedef struct packed {
    logic [11:0] rights;
    logic [31:0] base;
    logic [19:0] limit;
  } segCache_t;

  localparam int RIGHT_GRAN = 11;
  localparam int RIGHT_DPL  = 5;

endpackage

// File: rtl/segDescCtrl.sv
module segDescCtrl
  import segDescPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        protEn,
  input  logic        selWrEn,
  input  logic        selIsNull,
  input  logic        selOverrun,
  input  logic        memValid,
  input  logic        descPresent,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        loadDone,
  output ldCode_e     loadCode
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} state_e;

  state_e  state, stateNxt;
  logic    doneNxt;
  ldCode_e codeNxt;
  logic    accept;

  assign accept = protEn && selWrEn && (state == S_IDLE);
  assign busy   = (state != S_IDLE);
  assign memReq = (state == S_LO) || (state == S_HI);

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    codeNxt  = LD_OK;
    strobe   = '0;
    case (state)
      S_IDLE: begin
        if (accept) begin
          strobe.latchSel = 1'b1;
          if (selIsNull) begin
            strobe.commitNull = 1'b1;
            doneNxt = 1'b1;
          end else if (selOverrun) begin
            doneNxt = 1'b1;
            codeNxt = LD_OVERRUN;
          end else begin
            stateNxt = S_LO;
          end
        end
      end
      S_LO: begin
        if (memValid) begin
          strobe.latchLo = 1'b1;
          stateNxt = S_HI;
        end
      end
      S_HI: begin
        strobe.useHi = 1'b1;
        if (memValid) begin
          strobe.commitDesc = descPresent;
          doneNxt  = 1'b1;
          codeNxt  = descPresent ? LD_OK : LD_ABSENT;
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      loadDone <= 1'b0;
      loadCode <= LD_OK;
    end else begin
      state    <= stateNxt;
      loadDone <= doneNxt;
      loadCode <= codeNxt;
    end
  end

  // R2: requests only while a fetch is running
  p_req_in_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R2: completion of the high read is reported next cycle with busy gone
  p_done_after_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HI && memValid) |=> (loadDone && !busy));

  // R9: overrun completes immediately without a fetch
  p_overrun_quick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !selIsNull && selOverrun) |=> (loadDone && loadCode == LD_OVERRUN && !memReq));

  // R10: nothing starts while protection is off
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !protEn) |=> !busy);

endmodule

// File: rtl/segDescPath.sv
module segDescPath
  import segDescPkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int SEG_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protEn,
  input  ctrlStrobe_t       strobe,
  input  logic [SEG_W-1:0]  selWrSeg,
  input  logic [15:0]       selWrData,
  input  logic [31:0]       gdtBase,
  input  logic [15:0]       gdtLimit,
  input  logic [31:0]       ldtBase,
  input  logic [15:0]       ldtLimit,
  input  logic [31:0]       memData,
  input  logic              xlatEn,
  input  logic [SEG_W-1:0]  xlatSeg,
  input  logic [31:0]       xlatOffset,
  output logic              selIsNull,
  output logic              selOverrun,
  output logic              descPresent,
  output logic [31:0]       memAddr,
  output logic              xlatValid,
  output logic              xlatFault,
  output logic [31:0]       xlatAddr,
  output logic [1:0]        xlatRpl,
  output logic [1:0]        xlatDpl
);

  localparam int IDX_W = 13;

  logic [15:0]      selQ;
  logic [SEG_W-1:0] segQ;
  logic [31:0]      loQ;
  logic [15:0]      limSel;
  logic [31:0]      descAddr;
  segCache_t        newEntry;

  segCache_t        cacheQ  [NUM_SEGS];
  logic             usableQ [NUM_SEGS];
  logic [1:0]       rplQ    [NUM_SEGS];

  // incoming selector decode
  assign selIsNull  = (selWrData[15:2] == 14'd0);
  assign limSel     = selWrData[2] ? ldtLimit : gdtLimit;
  assign selOverrun = ({1'b0, selWrData[15:3], 3'b111} > {1'b0, limSel});

  // descriptor address from the latched selector
  assign descAddr = (selQ[2] ? ldtBase : gdtBase) + {16'd0, selQ[15:3], 3'b000};
  assign memAddr  = descAddr + (strobe.useHi ? 32'd4 : 32'd0);

  // unpack: high word present bit is byte 5 bit 7
  assign descPresent     = memData[15];
  assign newEntry.limit  = {memData[19:16], loQ[15:0]};
  assign newEntry.base   = {memData[31:24], memData[7:0], loQ[31:16]};
  assign newEntry.rights = {memData[23:20], memData[15:8]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      segQ <= '0;
      loQ  <= '0;
    end else begin
      if (strobe.latchSel) begin
        selQ <= selWrData;
        segQ <= selWrSeg;
      end
      if (strobe.latchLo) loQ <= memData;
    end
  end

  for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cacheQ[i]  <= '0;
        usableQ[i] <= 1'b0;
        rplQ[i]    <= '0;
      end else if (strobe.commitNull && selWrSeg == SEG_W'(i)) begin
        usableQ[i] <= 1'b0;
        rplQ[i]    <= selWrData[1:0];
      end else if (strobe.commitDesc && segQ == SEG_W'(i)) begin
        cacheQ[i]  <= newEntry;
        usableQ[i] <= 1'b1;
        rplQ[i]    <= selQ[1:0];
      end
    end
  end

  // translation, one register stage
  segCache_t  xEntry;
  logic       xUsable;
  logic [31:0] xEffLim;

  always_comb begin
    xEntry  = '0;
    xUsable = 1'b0;
    if (int'(xlatSeg) < NUM_SEGS) begin
      xEntry  = cacheQ[xlatSeg];
      xUsable = usableQ[xlatSeg];
    end
    xEffLim = xEntry.rights[RIGHT_GRAN] ? {xEntry.limit, 12'hFFF} : {12'd0, xEntry.limit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlatValid <= 1'b0;
      xlatFault <= 1'b0;
      xlatAddr  <= '0;
      xlatRpl   <= '0;
      xlatDpl   <= '0;
    end else begin
      xlatValid <= 1'b0;
      xlatFault <= 1'b0;
      xlatAddr  <= '0;
      if (xlatEn && protEn) begin
        xlatRpl <= (int'(xlatSeg) < NUM_SEGS) ? rplQ[xlatSeg] : 2'd0;
        xlatDpl <= xEntry.rights[RIGHT_DPL +: 2];
        if (!xUsable || xlatOffset > xEffLim) begin
          xlatFault <= 1'b1;
        end else begin
          xlatValid <= 1'b1;
          xlatAddr  <= xEntry.base + xlatOffset;
        end
      end
    end
  end

  // R5: valid and fault never together
  p_xlat_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(xlatValid && xlatFault));

  // R4: every enabled request gets an answer next cycle
  p_xlat_answer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (xlatEn && protEn) |=> (xlatValid || xlatFault));

  // R10: no result while protection is off
  p_xlat_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |=> !(xlatValid || xlatFault));

  // R1: the high read sits 4 bytes above the low read of the same selector
  p_hi_after_lo_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchLo && $stable(gdtBase) && $stable(ldtBase)) |=> (memAddr == $past(memAddr) + 32'd4));

endmodule

// File: rtl/segDescUnit.sv
module segDescUnit
  import segDescPkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int SEG_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protEn,
  input  logic              selWrEn,
  input  logic [SEG_W-1:0]  selWrSeg,
  input  logic [15:0]       selWrData,
  input  logic [31:0]       gdtBase,
  input  logic [15:0]       gdtLimit,
  input  logic [31:0]       ldtBase,
  input  logic [15:0]       ldtLimit,
  output logic              memReq,
  output logic [31:0]       memAddr,
  input  logic              memValid,
  input  logic [31:0]       memData,
  output logic              busy,
  output logic              loadDone,
  output logic [1:0]        loadCode,
  input  logic              xlatEn,
  input  logic [SEG_W-1:0]  xlatSeg,
  input  logic [31:0]       xlatOffset,
  output logic              xlatValid,
  output logic              xlatFault,
  output logic [31:0]       xlatAddr,
  output logic [1:0]        xlatRpl,
  output logic [1:0]        xlatDpl
);

  ctrlStrobe_t strobe;
  logic        selIsNull, selOverrun, descPresent;
  ldCode_e     codeQ;

  assign loadCode = codeQ;

  segDescCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .protEn(protEn), .selWrEn(selWrEn),
    .selIsNull(selIsNull), .selOverrun(selOverrun), .memValid(memValid),
    .descPresent(descPresent), .strobe(strobe), .memReq(memReq),
    .busy(busy), .loadDone(loadDone), .loadCode(codeQ)
  );

  segDescPath #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_path (
    .clk(clk), .rstN(rstN), .protEn(protEn), .strobe(strobe),
    .selWrSeg(selWrSeg), .selWrData(selWrData),
    .gdtBase(gdtBase), .gdtLimit(gdtLimit), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memData(memData), .xlatEn(xlatEn), .xlatSeg(xlatSeg), .xlatOffset(xlatOffset),
    .selIsNull(selIsNull), .selOverrun(selOverrun), .descPresent(descPresent),
    .memAddr(memAddr), .xlatValid(xlatValid), .xlatFault(xlatFault),
    .xlatAddr(xlatAddr), .xlatRpl(xlatRpl), .xlatDpl(xlatDpl)
  );

endmodule

// File: tb/tb_segDescUnit.sv
`timescale 1ns/1ps
module tb_segDescUnit;

  localparam logic [31:0] GDT_B = 32'h0010_0000;
  localparam logic [31:0] LDT_B = 32'h0012_0000;

  logic        clk = 1'b0;
  logic        rstN, protEn, selWrEn, memValid, xlatEn, stall;
  logic [2:0]  selWrSeg, xlatSeg;
  logic [15:0] selWrData, gdtLimit, ldtLimit;
  logic [31:0] memData, xlatOffset, curHi, curLo;
  logic        memReq, busy, loadDone, xlatValid, xlatFault;
  logic [31:0] memAddr, xlatAddr;
  logic [1:0]  loadCode, xlatRpl, xlatDpl;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign memValid = memReq && !stall;
  assign memData  = memAddr[2] ? curHi : curLo;

  segDescUnit dut (
    .clk(clk), .rstN(rstN), .protEn(protEn), .selWrEn(selWrEn), .selWrSeg(selWrSeg),
    .selWrData(selWrData), .gdtBase(GDT_B), .gdtLimit(gdtLimit), .ldtBase(LDT_B),
    .ldtLimit(ldtLimit), .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .busy(busy), .loadDone(loadDone), .loadCode(loadCode),
    .xlatEn(xlatEn), .xlatSeg(xlatSeg), .xlatOffset(xlatOffset), .xlatValid(xlatValid),
    .xlatFault(xlatFault), .xlatAddr(xlatAddr), .xlatRpl(xlatRpl), .xlatDpl(xlatDpl)
  );

  typedef struct packed {
    logic [2:0]  seg;
    logic [15:0] sel;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [31:0] off;
    logic        expFault;
    logic [31:0] expAddr;
    logic [1:0]  expDpl;
  } vec_t;

  // descriptors: lo = {base15:0, limit15:0}, hi = {base31:24, flags, limit19:16, rights, base23:16}
  localparam vec_t VECS [0:5] = '{
    '{3'd1, 16'h1007, 32'h0040_9240, 32'h0000_0FFF, 32'h0000_0010, 1'b0, 32'h0040_0010, 2'd0},
    '{3'd1, 16'h1007, 32'h0040_9240, 32'h0000_0FFF, 32'h0000_0FFF, 1'b0, 32'h0040_0FFF, 2'd0},
    '{3'd1, 16'h1007, 32'h0040_9240, 32'h0000_0FFF, 32'h0000_1000, 1'b1, 32'h0000_0000, 2'd0},
    '{3'd2, 16'h0010, 32'h12C0_F234, 32'h5678_0003, 32'h0000_3FFF, 1'b0, 32'h1234_9677, 2'd3},
    '{3'd2, 16'h0010, 32'h12C0_F234, 32'h5678_0003, 32'h0000_4000, 1'b1, 32'h0000_0000, 2'd3},
    '{3'd0, 16'h000B, 32'hFFCF_9AFF, 32'hF000_FFFF, 32'h0000_2000, 1'b0, 32'h0000_1000, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadSeg(input logic [2:0] seg, input logic [15:0] sel,
                         input logic [31:0] hi, input logic [31:0] lo, input logic [1:0] expCode);
    logic [31:0] ea;
    bit fetch;
    ea = (sel[2] ? LDT_B : GDT_B) + {16'd0, sel[15:3], 3'b000};
    fetch = (sel[15:2] != 14'd0) && (expCode != 2'd1);
    curHi = hi; curLo = lo;
    @(negedge clk); selWrEn = 1'b1; selWrSeg = seg; selWrData = sel;
    @(negedge clk); selWrEn = 1'b0;
    if (fetch) begin
      chk(memReq && busy, "R2 req/busy during fetch", {30'd0, memReq, busy}, 32'd3);
      chk(memAddr == ea, "R1 low word address", memAddr, ea);
      @(negedge clk);
      chk(memAddr == ea + 32'd4, "R1 high word address", memAddr, ea + 32'd4);
      @(negedge clk);
    end else begin
      chk(!memReq, "R8/R9 no read issued", {31'd0, memReq}, 32'd0);
    end
    chk(loadDone && !busy, "R2 done pulse", {30'd0, loadDone, busy}, 32'd2);
    chk(loadCode == expCode, "R7/R9 load code", {30'd0, loadCode}, {30'd0, expCode});
  endtask

  task automatic xlat(input logic [2:0] seg, input logic [31:0] off,
                      input bit expFault, input logic [31:0] expAddr, input string req);
    @(negedge clk); xlatEn = 1'b1; xlatSeg = seg; xlatOffset = off;
    @(negedge clk); xlatEn = 1'b0;
    chk(xlatFault == expFault && xlatValid == !expFault, {req, " valid/fault"},
        {30'd0, xlatValid, xlatFault}, {30'd0, !expFault, expFault});
    if (!expFault) chk(xlatAddr == expAddr, {req, " address"}, xlatAddr, expAddr);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; protEn = 1; selWrEn = 0; selWrSeg = 0; selWrData = 0; stall = 0;
    xlatEn = 0; xlatSeg = 0; xlatOffset = 0; curHi = 0; curLo = 0;
    gdtLimit = 16'hFFFF; ldtLimit = 16'h1FFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !memReq && !loadDone && !xlatValid && !xlatFault, "R2 reset outputs idle",
        {27'd0, busy, memReq, loadDone, xlatValid, xlatFault}, 32'd0);
    xlat(3'd3, 32'd0, 1'b1, 32'd0, "R8 unusable after reset");

    // vector table: load, then translate (R1-R6, R12)
    for (int i = 0; i < 6; i++) begin
      loadSeg(VECS[i].seg, VECS[i].sel, VECS[i].hi, VECS[i].lo, 2'd0);
      xlat(VECS[i].seg, VECS[i].off, VECS[i].expFault, VECS[i].expAddr, "R3/R4/R5/R6 vector");
      if (!VECS[i].expFault) begin
        chk(xlatRpl == VECS[i].sel[1:0] && xlatDpl == VECS[i].expDpl, "R12 privilege report",
            {28'd0, xlatRpl, xlatDpl}, {28'd0, VECS[i].sel[1:0], VECS[i].expDpl});
      end
    end

    // R10: protection off
    protEn = 0;
    @(negedge clk); selWrEn = 1; selWrSeg = 3'd0; selWrData = 16'h0010;
    @(negedge clk); selWrEn = 0;
    chk(!busy && !memReq && !loadDone, "R10 write ignored", {29'd0, busy, memReq, loadDone}, 32'd0);
    @(negedge clk); xlatEn = 1; xlatSeg = 3'd0; xlatOffset = 0;
    @(negedge clk); xlatEn = 0;
    chk(!xlatValid && !xlatFault, "R10 no translate result", {30'd0, xlatValid, xlatFault}, 32'd0);
    protEn = 1;
    xlat(3'd0, 32'd0, 1'b0, 32'hFFFF_F000, "R10 cache untouched");

    // R7: not present keeps old contents
    loadSeg(3'd0, 16'h0018, 32'h0040_1240, 32'h0000_0FFF, 2'd2);
    xlat(3'd0, 32'd0, 1'b0, 32'hFFFF_F000, "R7 old contents kept");

    // R9: table overrun keeps old contents
    ldtLimit = 16'h0FFF;
    loadSeg(3'd2, 16'h1007, 32'h0040_9240, 32'h0000_0FFF, 2'd1);
    xlat(3'd2, 32'h10, 1'b0, 32'h1234_5688, "R9 old contents kept");
    ldtLimit = 16'h1FFF;

    // R8: null selector
    loadSeg(3'd1, 16'h0003, 32'h0, 32'h0, 2'd0);
    xlat(3'd1, 32'd0, 1'b1, 32'd0, "R8 null segment faults");

    // R11: write during fetch dropped
    curHi = 32'h12C0_F234; curLo = 32'h5678_0003;
    @(negedge clk); selWrEn = 1; selWrSeg = 3'd3; selWrData = 16'h0010;
    @(negedge clk); selWrSeg = 3'd4;
    @(negedge clk); selWrEn = 0;
    @(negedge clk);
    chk(loadDone, "R11 first load completes", {31'd0, loadDone}, 32'd1);
    @(negedge clk);
    chk(!busy && !memReq, "R11 no second fetch", {30'd0, busy, memReq}, 32'd0);
    xlat(3'd4, 32'd0, 1'b1, 32'd0, "R11 dropped segment unloaded");
    xlat(3'd3, 32'd0, 1'b0, 32'h1234_5678, "R11 first segment loaded");

    // R2: stalled memory
    stall = 1; curHi = 32'hFFCF_9AFF; curLo = 32'hF000_FFFF;
    @(negedge clk); selWrEn = 1; selWrSeg = 3'd5; selWrData = 16'h000B;
    @(negedge clk); selWrEn = 0;
    for (int k = 0; k < 3; k++) begin
      chk(memReq && !loadDone && memAddr == 32'h0010_0008, "R2 stall holds request", memAddr, 32'h0010_0008);
      @(negedge clk);
    end
    stall = 0;
    @(negedge clk);
    chk(memAddr == 32'h0010_000C, "R2 high read after stall", memAddr, 32'h0010_000C);
    @(negedge clk);
    chk(loadDone && loadCode == 2'd0, "R2 done after stall", {30'd0, loadCode}, 32'd0);
    xlat(3'd5, 32'd4, 1'b0, 32'hFFFF_F004, "R4 stalled load usable");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule